// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the pin-side engine of a processor bus interface. A core hands it one transfer at a time, made of an address, a memory/I-O select, a direction, write data, a segment tag and the interrupt-enable flag. The sequencer turns each transfer into a four-state bus cycle on one shared set of 20 lines. Those lines carry the address first, then the status bits on the top four lines while the low sixteen carry or receive the data. An address-latch strobe marks the address phase so that external logic can capture it. Active-low read and write strobes and a memory/I-O indicator qualify the transfer.

Slow targets stretch the cycle by holding `ready` low, and each wait state adds one clock. An external master can take the bus with `hold`. The sequencer finishes the cycle in flight, raises `hlda` and floats every bus output until `hold` drops. Out of reset the sequencer runs one memory read at the reset vector on its own before it accepts any core request.

Top module: `mxbus_seq`

## Requirements
- R1: In T1, `ale` is 1 and `ad_out` carries the cycle address with both output enables set. For a memory cycle all 20 bits are driven. For an I/O cycle bits 19:16 are 0 and bits 15:0 carry the port address.
- R2: `mio` is 0 for a memory cycle and 1 for an I/O cycle, and it holds that value from T1 through T4.
- R3: From T2 through T4, `ad_out[19:16]` carries status. Bit 19 is always 0, bit 18 is the interrupt-enable flag given with the request, and bits 17:16 are the segment tag.
- R4: In a read, `rd_n` is low from T2 until the last state before T4 and `ad_oe_lo` is 0 from T2 through T4. `ad_in` is captured at the edge that enters T4, and it appears on `rsp_rdata` while `rsp_done` is 1 for the one T4 clock.
- R5: In a write, `wr_n` is low over the same states, and `req_wdata` is driven on `ad_out[15:0]` with `ad_oe_lo` set from T2 to the end of T4. `rsp_done` is 1 in T4.
- R6: If `ready` is 1 at the edge that ends T2, the strobe stays low for exactly 2 clocks. If `ready` is 0 at that edge, a wait state follows T3. Each wait state whose ending edge still sees `ready` at 0 adds one more, so n wait states give a strobe that is low for 2+n clocks, and T4 begins 3+n clocks after T1.
- R7: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is 1.
- R8: After reset, `req_ready` stays 0 until the sequencer has run its own memory read at 0xFFFF0 with segment tag 2'b10. `rsp_boot` is 1 only in the T4 of that read.
- R9: `req_ready` is 1 only in the idle state or in T4. A request accepted in T4 starts its T1 on the next clock.
- R10: When `hold` rises during a cycle, the cycle runs to T4. On the next clock `hlda` is 1 and `ad_oe_lo`, `ad_oe_hi` and `ctl_oe` are all 0. If `hold` and `req_valid` are both 1 in T4, the hold wins and the request waits. One clock after `hold` falls, the sequencer is idle and accepts requests again.
- R11: While reset is asserted, `ale` is 0, `rd_n` and `wr_n` are 1, `hlda` is 0 and `rsp_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a transfer to issue |
| req_ready | output | 1 | Transfer accepted at this edge if valid |
| req_addr | input | 20 | Transfer address |
| req_io | input | 1 | 1 selects the I/O space |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 16 | Write data |
| req_seg | input | 2 | Segment tag placed in the status |
| req_ie | input | 1 | Interrupt-enable flag placed in the status |
| rsp_done | output | 1 | Cycle in T4 |
| rsp_boot | output | 1 | The finishing cycle is the reset-vector fetch |
| rsp_rdata | output | 16 | Captured read data |
| ad_out | output | 20 | Shared address/status/data lines, outgoing value |
| ad_oe_lo | output | 1 | Drive enable for lines 15:0 |
| ad_oe_hi | output | 1 | Drive enable for lines 19:16 |
| ad_in | input | 16 | Shared lines 15:0, incoming value |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | 0 memory, 1 I/O |
| ctl_oe | output | 1 | Drive enable for `ale`, `rd_n`, `wr_n` and `mio` |
| ready | input | 1 | Target ready; low inserts wait states |
| hold | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus granted to the external master |

## Verification
In T4 the sequencer must decide between two things that can arrive on the same clock: a new core request that wants an immediate T1, and a bus hold from an external master. The bench raises `hold` while a read is still in flight and keeps `req_valid` high into its T4. It then checks that `req_ready` stays 0 in that T4 and that the next clock shows `hlda` with every output floated and no `ale`. After `hold` drops, the waiting request must run at its own address. A separate run keeps `req_valid` high without a hold and confirms that the second cycle's T1 follows the first cycle's T4 directly.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } bus_st_e;

  typedef struct packed {
    logic       io;
    logic       wr;
    logic [1:0] seg;
    logic       ie;
    logic       boot;
  } cyc_attr_t;

  localparam logic [1:0] SEG_CODE = 2'b10;

endpackage

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_io,
  input  logic      req_write,
  input  logic [1:0] req_seg,
  input  logic      req_ie,
  input  logic      ready,
  input  logic      hold,
  output logic      req_ready,
  output logic      load,
  output logic      boot_go,
  output logic      cap,
  output bus_st_e   st,
  output cyc_attr_t cyc
);

  bus_st_e   st_q, st_d;
  cyc_attr_t cyc_q, cyc_d;
  logic      bootp_q, bootp_d;
  logic      wait_q, wait_d;
  logic      rdy, acc, bgo;

  always_comb begin
    rdy   = !hold && ((st_q == ST_IDLE && !bootp_q) || st_q == ST_T4);
    acc   = req_valid && rdy;
    bgo   = (st_q == ST_IDLE) && bootp_q && !hold;
    st_d    = st_q;
    cyc_d   = cyc_q;
    bootp_d = bootp_q;
    wait_d  = wait_q;
    if (bgo) begin
      bootp_d = 1'b0;
      cyc_d   = '{io: 1'b0, wr: 1'b0, seg: SEG_CODE, ie: 1'b0, boot: 1'b1};
    end else if (acc) begin
      cyc_d   = '{io: req_io, wr: req_write, seg: req_seg, ie: req_ie, boot: 1'b0};
    end
    if (st_q == ST_T2) wait_d = !ready;
    unique case (st_q)
      ST_IDLE: if (hold) st_d = ST_HOLD;
               else if (bgo || acc) st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3:   st_d = wait_q ? ST_TW : ST_T4;
      ST_TW:   st_d = ready ? ST_T4 : ST_TW;
      ST_T4:   if (acc) st_d = ST_T1;
               else if (hold) st_d = ST_HOLD;
               else st_d = ST_IDLE;
      ST_HOLD: st_d = hold ? ST_HOLD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cyc_q   <= '0;
      bootp_q <= 1'b1;
      wait_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      bootp_q <= bootp_d;
      if (bgo || acc) cyc_q <= cyc_d;
      if (st_q == ST_T2) wait_q <= wait_d;
    end
  end

  assign req_ready = rdy;
  assign load      = acc;
  assign boot_go   = bgo;
  assign cap       = (st_d == ST_T4);
  assign st        = st_q;
  assign cyc       = cyc_q;

  // R9: a T1 only ever follows idle or T4
  a_r9_t1_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T1) |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_T4));

  // R10: a cycle in flight is never cut short by hold
  a_r10_finish_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && (st_q == ST_T2 || st_q == ST_T3 || st_q == ST_TW))
      |=> (st_q != ST_HOLD && st_q != ST_IDLE));

  // R6: not-ready at the end of T2 always yields a wait state after T3
  a_r6_wait_inserted: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T2 && !ready) |=> ##1 (st_q == ST_TW));

endmodule

// File: rtl/mxbus_drv.sv
module mxbus_drv
  import mxbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_VEC = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_st_e       st,
  input  cyc_attr_t     cyc,
  input  logic          load,
  input  logic          boot_go,
  input  logic          cap,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe_lo,
  output logic          ad_oe_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          ctl_oe,
  output logic          hlda,
  output logic          rsp_done,
  output logic          rsp_boot,
  output logic [DW-1:0] rsp_rdata
);

  localparam int HI = AW - DW;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;
  logic          strobe_ph, busy_ph;
  logic [HI-1:0] stat_v, hi_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (boot_go)   addr_q <= RESET_VEC;
      else if (load) addr_q <= req_addr;
      if (load) wdat_q <= req_wdata;
      if (cap && !cyc.wr) rdat_q <= ad_in;
    end
  end

  always_comb begin
    strobe_ph = (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
    busy_ph   = strobe_ph || (st == ST_T1) || (st == ST_T4);
    stat_v    = '0;
    stat_v[2:0] = {cyc.ie, cyc.seg};
    hi_addr   = cyc.io ? '0 : addr_q[AW-1:DW];
    ale       = (st == ST_T1);
    rd_n      = !(strobe_ph && !cyc.wr);
    wr_n      = !(strobe_ph && cyc.wr);
    ad_oe_hi  = busy_ph;
    ad_oe_lo  = (st == ST_T1) || (busy_ph && cyc.wr);
    ad_out    = (st == ST_T1) ? {hi_addr, addr_q[DW-1:0]} : {stat_v, wdat_q};
    mio       = cyc.io;
    ctl_oe    = (st != ST_HOLD);
    hlda      = (st == ST_HOLD);
    rsp_done  = (st == ST_T4);
    rsp_boot  = (st == ST_T4) && cyc.boot;
  end

  assign rsp_rdata = rdat_q;

  // R7: the two strobes are mutually exclusive
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7: no strobe during the address phase
  a_r7_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R4: the block never drives the low lines while a target may answer
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe_lo);

  // R10: everything floats while the bus is granted away
  a_r10_float: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe_lo && !ad_oe_hi && !ctl_oe));

  // R4: completion is always preceded by an active strobe
  a_r4_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(!rd_n) || $past(!wr_n)));

endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_VEC = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_io,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_seg,
  input  logic          req_ie,
  output logic          rsp_done,
  output logic          rsp_boot,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe_lo,
  output logic          ad_oe_hi,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          ctl_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);

  bus_st_e   st;
  cyc_attr_t cyc;
  logic      load, boot_go, cap;

  mxbus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_io(req_io), .req_write(req_write),
    .req_seg(req_seg), .req_ie(req_ie), .ready(ready), .hold(hold),
    .req_ready(req_ready), .load(load), .boot_go(boot_go), .cap(cap),
    .st(st), .cyc(cyc)
  );

  mxbus_drv #(.AW(AW), .DW(DW), .RESET_VEC(RESET_VEC)) u_drv (
    .clk(clk), .rst_n(rst_n), .st(st), .cyc(cyc),
    .load(load), .boot_go(boot_go), .cap(cap),
    .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .ctl_oe(ctl_oe),
    .hlda(hlda), .rsp_done(rsp_done), .rsp_boot(rsp_boot),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/mxbus_seq_test.sv
`timescale 1ns/1ps
module mxbus_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_io, req_write, req_ie;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_seg;
  logic        rsp_done, rsp_boot;
  logic [15:0] rsp_rdata;
  logic [19:0] ad_out;
  logic        ad_oe_lo, ad_oe_hi;
  logic [15:0] ad_in;
  logic        ale, rd_n, wr_n, mio, ctl_oe, ready, hold, hlda;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mxbus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .req_write(req_write),
    .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie),
    .rsp_done(rsp_done), .rsp_boot(rsp_boot), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .ctl_oe(ctl_oe),
    .ready(ready), .hold(hold), .hlda(hlda)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [19:0] a, input logic io, input logic w,
                       input logic [15:0] wd, input logic [1:0] sg, input logic ie);
    logic r;
    req_addr = a; req_io = io; req_write = w; req_wdata = wd;
    req_seg = sg; req_ie = ie; req_valid = 1'b1;
    do begin
      r = req_ready;
      @(negedge clk);
    end while (!r);
    req_valid = 1'b0;
  endtask

  // one complete cycle with nw wait states; returns at the T4 negedge
  task automatic run_cycle(input logic [19:0] a, input logic io, input logic w,
                           input logic [15:0] wd, input logic [1:0] sg,
                           input logic ie, input int nw, input logic [15:0] rv);
    int k;
    int lowcnt;
    logic [19:0] ea;
    ad_in = rv;
    ready = 1'b1;
    issue(a, io, w, wd, sg, ie);
    ea = io ? {4'h0, a[15:0]} : a;
    check(ale && ad_oe_lo && ad_oe_hi && ad_out == ea, "R1 address phase", ad_out, ea);
    check(mio == io, "R2 space select", mio, io);
    k = 0;
    lowcnt = 0;
    while (!rsp_done && k < 40) begin
      @(negedge clk);
      k++;
      ready = (nw == 0) || (k == 2 + nw);
      if (!rd_n || !wr_n) lowcnt++;
      if (k == 1) begin
        check(ad_out[19:16] == {1'b0, ie, sg}, "R3 status bits", ad_out[19:16], {1'b0, ie, sg});
        if (w)
          check(!wr_n && rd_n && ad_oe_lo && ad_out[15:0] == wd, "R5 write data in T2",
                ad_out[15:0], wd);
        else
          check(!rd_n && wr_n && !ad_oe_lo, "R4 read turnaround in T2",
                {rd_n, wr_n, ad_oe_lo}, 3'b010);
      end
    end
    ready = 1'b1;
    check(k == 3 + nw, "R6 T4 position", k, 3 + nw);
    check(lowcnt == 2 + nw, "R6 strobe length", lowcnt, 2 + nw);
    check(mio == io, "R2 space held to T4", mio, io);
    if (w)
      check(ad_oe_lo && wr_n && ad_out[15:0] == wd, "R5 data held in T4", ad_out[15:0], wd);
    else
      check(!ad_oe_lo && rd_n && rsp_rdata == rv, "R4 read data", rsp_rdata, rv);
  endtask

  task automatic t_reset_boot;
    int k;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!ale && rd_n && wr_n && !hlda && !rsp_done, "R11 reset state",
          {ale, rd_n, wr_n, hlda, rsp_done}, 5'b01100);
    ad_in = 16'hEA5B;
    rst_n = 1'b1;
    check(!req_ready, "R8 no accept before boot fetch", req_ready, 0);
    k = 0;
    while (!ale && k < 10) begin @(negedge clk); k++; end
    check(ad_out == 20'hFFFF0 && !mio, "R8 boot address", ad_out, 20'hFFFF0);
    @(negedge clk);
    check(ad_out[17:16] == 2'b10, "R8 boot segment tag", ad_out[17:16], 2'b10);
    k = 0;
    while (!rsp_done && k < 10) begin
      check(!req_ready, "R8 no accept during boot", req_ready, 0);
      @(negedge clk); k++;
    end
    check(rsp_boot && rsp_rdata == 16'hEA5B, "R8 boot completion", rsp_rdata, 16'hEA5B);
    @(negedge clk);
    check(req_ready && !rsp_boot, "R8 ready after boot", req_ready, 1);
  endtask

  task automatic t_back_to_back;
    int k;
    ready = 1'b1;
    issue(20'h1_2340, 1'b0, 1'b0, 16'h0, 2'b11, 1'b0);
    check(!req_ready, "R9 no accept in T1", req_ready, 0);
    req_addr = 20'h0_0ABC; req_io = 1'b1; req_write = 1'b1; req_wdata = 16'h7E81;
    req_seg = 2'b00; req_ie = 1'b1; req_valid = 1'b1;
    k = 0;
    while (!rsp_done && k < 10) begin
      @(negedge clk); k++;
      if (!rsp_done) check(!req_ready, "R9 no accept mid-cycle", req_ready, 0);
    end
    check(req_ready, "R9 accept in T4", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(ale && ad_out == 20'h0_0ABC && mio, "R9 back-to-back T1", ad_out, 20'h0_0ABC);
    k = 0;
    while (!rsp_done && k < 10) begin @(negedge clk); k++; end
    check(ad_out[15:0] == 16'h7E81 && ad_oe_lo, "R5 second cycle write", ad_out[15:0], 16'h7E81);
    @(negedge clk);
  endtask

  task automatic t_hold_collision;
    int k;
    ready = 1'b1;
    ad_in = 16'h3C3C;
    issue(20'h5_5550, 1'b0, 1'b0, 16'h0, 2'b01, 1'b1);
    hold = 1'b1;
    req_addr = 20'hA_0001; req_io = 1'b0; req_write = 1'b0; req_valid = 1'b1;
    k = 0;
    while (!rsp_done && k < 10) begin
      @(negedge clk); k++;
      if (!rsp_done) check(!hlda && ctl_oe, "R10 cycle not cut", hlda, 0);
    end
    check(rsp_done && rsp_rdata == 16'h3C3C, "R10 cycle finished under hold", rsp_rdata, 16'h3C3C);
    check(!req_ready, "R10 hold beats request in T4", req_ready, 0);
    repeat (3) begin
      @(negedge clk);
      check(hlda && !ad_oe_lo && !ad_oe_hi && !ctl_oe && !ale, "R10 bus floated",
            {hlda, ad_oe_lo, ad_oe_hi, ctl_oe}, 4'b1000);
    end
    hold = 1'b0;
    @(negedge clk);
    check(!hlda && req_ready, "R10 idle after release", {hlda, req_ready}, 2'b01);
    @(negedge clk);
    req_valid = 1'b0;
    check(ale && ad_out == 20'hA_0001, "R10 pending request runs", ad_out, 20'hA_0001);
    k = 0;
    while (!rsp_done && k < 10) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_io = 1'b0;
    req_write = 1'b0; req_wdata = '0; req_seg = '0; req_ie = 1'b0;
    ad_in = '0; ready = 1'b1; hold = 1'b0;
    t_reset_boot();
    run_cycle(20'hC_1234, 1'b0, 1'b0, 16'h0,    2'b00, 1'b1, 0, 16'hBEEF);
    run_cycle(20'h3_8002, 1'b0, 1'b1, 16'h55AA, 2'b11, 1'b0, 0, 16'h0);
    run_cycle(20'hF_00F8, 1'b1, 1'b0, 16'h0,    2'b01, 1'b0, 1, 16'h1357);
    run_cycle(20'h0_4421, 1'b1, 1'b1, 16'h9AC3, 2'b10, 1'b1, 3, 16'h0);
    run_cycle(20'h7_FFFE, 1'b0, 1'b0, 16'h0,    2'b10, 1'b1, 2, 16'h8001);
    t_back_to_back();
    t_hold_collision();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule